// File: doc/BRIEF.md
# Real-Time-Clock Register Bank with Alarm Compare

This block is the register bank of a small real-time-clock device, as seen from a byte-wide serial target port. A host opens a transaction with a start strobe. In a write transaction the first byte loads a 4-bit register pointer. Every later byte is stored at the pointer, and the pointer then steps forward. In a read transaction each byte comes from the pointer, and the pointer steps forward after each one. The bank holds sixteen 8-bit registers:

- control/status words
- BCD time fields
- four alarm fields
- timer and clock-out control bytes

Whenever an alarm or matching time field is written, the block compares every enabled alarm field with its time field. A match sets a sticky alarm flag. An active-low interrupt output follows the flag gated by an enable bit.

A separate backdoor write port lets a test environment load any register, typically the time fields. It has the same side effects as a host write. Counting real time, clock-out generation, the countdown timer and the bit-level serial physical layer are not part of this block.

Top module: `rtc_regbank`

## Requirements
- R1: Synchronous active-high reset loads these values:
  - address 0x00 = 0x08
  - address 0x02 = 0x80
  - addresses 0x09–0x0C = 0x80
  - address 0x0D = 0x80
  - address 0x0E = 0x03
  - every other address = 0x00
  After reset the pointer is 0 and `rd_byte` is 0x00.
- R2: After `xfer_start`, the first `wr_valid` byte sets the pointer to its low 4 bits and writes no register. Each later `wr_valid` byte is stored at the pointer, and the pointer then increments.
- R3: A `rd_req` cycle (with no `xfer_start` and no `wr_valid` in that cycle) places the register at the pointer on `rd_byte` one clock later and increments the pointer. `rd_byte` holds its value otherwise.
- R4: The pointer is 4 bits and wraps from 0x0F to 0x00 on increment, for both reads and writes.
- R5: Alarm fields live at 0x09 (minute), 0x0A (hour), 0x0B (day) and 0x0C (weekday). They pair with time fields 0x03, 0x04, 0x05 and 0x06. An alarm field with bit 7 set is disabled and ignored. The match is true when every enabled field equals its paired time byte, so with all fields disabled the match is true.
- R6: The compare runs only on a register write to 0x03–0x06 or 0x09–0x0C, using the register values after that write. Writes to any other address never set the alarm flag.
- R7: The alarm flag is bit 3 of address 0x01. A true compare sets it. A false compare never clears it. Only a write storing 0 into that bit clears it.
- R8: `irq_n` is low exactly when bits 1 (enable) and 3 (flag) of address 0x01 are both 1. It is high during reset and in the cycle after it.
- R9: A backdoor write (`bd_we`) stores `bd_data` at `bd_addr` and has the same compare effect as a host write. In a cycle where the host writes a register, the backdoor write is discarded.
- R10: A read issued right after `xfer_start`, with no pointer byte, returns the register at the pointer left by earlier transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transaction start strobe; the next write byte is a pointer |
| wr_valid | input | 1 | Host write byte strobe |
| wr_byte | input | 8 | Host write byte (pointer or data) |
| rd_req | input | 1 | Host read byte request |
| rd_byte | output | 8 | Read data, valid the cycle after `rd_req` |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | 4 | Backdoor register address |
| bd_data | input | 8 | Backdoor write data |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit registers, a 4-bit pointer and four alarm fields. With these sizes a 17-byte read burst crosses the pointer wrap, and a two-byte write burst from 0x0F lands on 0x00. The four-field compare can then be driven through its all-disabled case, a single disabled field, a full match and a mismatch. A behavioural model runs beside the design on every clock and predicts `rd_byte` and `irq_n`. Directed steps cover flag stickiness, non-trigger writes while the fields already match, and a host/backdoor collision.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 16;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int NUM_ALM  = 4;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CTRL1   = addr_t'(0);
    localparam addr_t A_CTRL2   = addr_t'(1);
    localparam addr_t A_SEC     = addr_t'(2);
    localparam addr_t A_TIME0   = addr_t'(3);
    localparam addr_t A_ALM0    = addr_t'(9);
    localparam addr_t A_CLKOUT  = addr_t'(13);
    localparam addr_t A_TMRCTL  = addr_t'(14);

    localparam int FLAG_BIT = 3;
    localparam int IEN_BIT  = 1;
    localparam int OFF_BIT  = DATA_W - 1;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_op_t;

    function automatic byte_t reset_value(addr_t a);
        byte_t v;
        v = '0;
        if (a == A_CTRL1)                              v = 8'h08;
        if (a == A_SEC || a == A_CLKOUT)               v = 8'h80;
        if (a >= A_ALM0 && a < A_ALM0 + addr_t'(NUM_ALM)) v = 8'h80;
        if (a == A_TMRCTL)                             v = 8'h03;
        return v;
    endfunction

    function automatic logic is_trigger(addr_t a);
        return (a >= A_TIME0 && a < A_TIME0 + addr_t'(NUM_ALM)) ||
               (a >= A_ALM0  && a < A_ALM0  + addr_t'(NUM_ALM));
    endfunction
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  xfer_start,
    input  logic  wr_valid,
    input  byte_t wr_byte,
    input  logic  rd_req,
    output wr_op_t host_op,
    output logic  rd_fire,
    output addr_t ptr_q
);
    logic want_ptr_q;

    always_comb begin
        host_op.en   = !xfer_start && wr_valid && !want_ptr_q;
        host_op.addr = ptr_q;
        host_op.data = wr_byte;
        rd_fire      = !xfer_start && !wr_valid && rd_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            want_ptr_q <= 1'b0;
        end else if (xfer_start) begin
            want_ptr_q <= 1'b1;
        end else if (wr_valid) begin
            if (want_ptr_q) begin
                ptr_q      <= ADDR_W'(wr_byte);
                want_ptr_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end else if (rd_req) begin
            ptr_q      <= ptr_q + 1'b1;
            want_ptr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int NF = 4,
    parameter int DW = 8
) (
    input  logic [NF-1:0][DW-1:0] time_f,
    input  logic [NF-1:0][DW-1:0] alarm_f,
    output logic                  match
);
    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign field_ok[i] = alarm_f[i][DW-1] || (alarm_f[i] == time_f[i]);
    end

    assign match = &field_ok;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_start,
    input  logic        wr_valid,
    input  logic [7:0]  wr_byte,
    input  logic        rd_req,
    output logic [7:0]  rd_byte,
    input  logic        bd_we,
    input  logic [3:0]  bd_addr,
    input  logic [7:0]  bd_data,
    output logic        irq_n
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs, wr_img, nxt;
    logic [NUM_ALM-1:0][DATA_W-1:0]  time_f, alarm_f;
    wr_op_t host_op, sel_op;
    logic   rd_fire, hit, match;
    addr_t  ptr_q;
    logic   sel_we;
    addr_t  sel_addr;

    rtc_host_port u_port (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .rd_req(rd_req), .host_op(host_op),
        .rd_fire(rd_fire), .ptr_q(ptr_q)
    );

    // host register write has priority; a colliding backdoor write is dropped
    always_comb begin
        if (host_op.en) sel_op = host_op;
        else            sel_op = '{en: bd_we, addr: bd_addr, data: bd_data};
    end
    assign sel_we   = sel_op.en;
    assign sel_addr = sel_op.addr;

    always_comb begin
        wr_img = regs;
        if (sel_op.en) wr_img[sel_op.addr] = sel_op.data;
    end

    for (genvar i = 0; i < NUM_ALM; i++) begin : g_pair
        assign time_f[i]  = wr_img[A_TIME0 + addr_t'(i)];
        assign alarm_f[i] = wr_img[A_ALM0 + addr_t'(i)];
    end

    rtc_alarm_match #(.NF(NUM_ALM), .DW(DATA_W)) u_match (
        .time_f(time_f), .alarm_f(alarm_f), .match(match)
    );

    always_comb begin
        hit = sel_op.en && is_trigger(sel_op.addr);
        nxt = wr_img;
        if (hit && match) nxt[A_CTRL2][FLAG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(addr_t'(i));
            irq_n   <= 1'b1;
            rd_byte <= '0;
        end else begin
            regs  <= nxt;
            irq_n <= !(nxt[A_CTRL2][IEN_BIT] && nxt[A_CTRL2][FLAG_BIT]);
            if (rd_fire) rd_byte <= regs[ptr_q];
        end
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import rtc_regbank_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  irq_n,
    input byte_t ctrl2,
    input logic  wr_en,
    input addr_t wr_addr,
    input logic  host_we,
    input addr_t host_addr,
    input addr_t ptr,
    input logic  bd_we
);
    // R8: interrupt level tracks enable and flag of the status word
    p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
        irq_n == !(ctrl2[IEN_BIT] && ctrl2[FLAG_BIT]));

    // R8: high in the cycle after reset
    p_irq_after_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> irq_n);

    // R7: flag stays set unless the status word is written
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl2[FLAG_BIT] && !(wr_en && wr_addr == A_CTRL2) |=> ctrl2[FLAG_BIT]);

    // R6: non-trigger writes never raise the flag
    p_no_trigger_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl2[FLAG_BIT] && !(wr_en && (is_trigger(wr_addr) || wr_addr == A_CTRL2))
        |=> !ctrl2[FLAG_BIT]);

    // R4: pointer wraps on a data write at the top address
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        host_we && ptr == addr_t'(NUM_REGS - 1) |=> ptr == '0);

    // R9: the host wins a collision with the backdoor
    p_host_wins_r9: assert property (@(posedge clk) disable iff (rst)
        host_we && bd_we |-> wr_addr == host_addr);
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
    .clk(clk), .rst(rst), .irq_n(irq_n), .ctrl2(regs[1]),
    .wr_en(sel_we), .wr_addr(sel_addr), .host_we(host_op.en),
    .host_addr(host_op.addr), .ptr(ptr_q), .bd_we(bd_we)
);

// File: tb/test_rtc_regbank.sv
`timescale 1ns/1ps
module test_rtc_regbank;
    logic clk = 0, rst = 1;
    logic xfer_start = 0, wr_valid = 0, rd_req = 0, bd_we = 0;
    logic [7:0] wr_byte = 0, bd_data = 0;
    logic [3:0] bd_addr = 0;
    logic [7:0] rd_byte;
    logic irq_n;

    int nchk = 0, nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_regbank i_rtc_regbank (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .rd_req(rd_req), .rd_byte(rd_byte),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data), .irq_n(irq_n)
    );

    function automatic int rv(int a);
        if (a == 0) return 8'h08;
        if (a == 2 || a == 13 || (a >= 9 && a <= 12)) return 8'h80;
        if (a == 14) return 8'h03;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model, stepped on every falling edge
    int mreg[16];
    int mptr = 0, mrd = 0, mirq_n = 1;
    bit mexp = 0;
    always @(negedge clk) begin
        bit w, ok;
        int wa, wd;
        if (rst) begin
            for (int i = 0; i < 16; i++) mreg[i] = rv(i);
            mptr = 0; mexp = 0; mrd = 0; mirq_n = 1;
        end else begin
            w = 0; wa = 0; wd = 0;
            if (xfer_start) mexp = 1;
            else if (wr_valid) begin
                if (mexp) begin mptr = wr_byte % 16; mexp = 0; end
                else begin w = 1; wa = mptr; wd = wr_byte; mptr = (mptr + 1) % 16; end
            end else if (rd_req) begin
                mrd = mreg[mptr]; mptr = (mptr + 1) % 16; mexp = 0;
            end
            if (!w && bd_we) begin w = 1; wa = bd_addr; wd = bd_data; end
            if (w) begin
                mreg[wa] = wd;
                if ((wa >= 3 && wa <= 6) || (wa >= 9 && wa <= 12)) begin
                    ok = 1;
                    for (int k = 0; k < 4; k++)
                        if ((mreg[9+k] & 8'h80) == 0 && mreg[9+k] != mreg[3+k]) ok = 0;
                    if (ok) mreg[1] = mreg[1] | 8'h08;
                end
            end
            mirq_n = ((mreg[1] & 2) != 0 && (mreg[1] & 8) != 0) ? 0 : 1;
        end
        chk("R3 model rd_byte", rd_byte, mrd);
        chk("R8 model irq_n", irq_n, mirq_n);
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic do_start();
        xfer_start = 1; tick(); xfer_start = 0;
    endtask

    task automatic put(int b);
        wr_valid = 1; wr_byte = 8'(b); tick(); wr_valid = 0;
    endtask

    task automatic get(output int b);
        rd_req = 1; tick(); rd_req = 0; b = rd_byte;
    endtask

    task automatic write_reg(int a, int d);
        do_start(); put(a); put(d);
    endtask

    task automatic read_at(int a, output int b);
        do_start(); put(a); do_start(); get(b);
    endtask

    task automatic bd(int a, int d);
        bd_we = 1; bd_addr = 4'(a); bd_data = 8'(d); tick(); bd_we = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int v;
        tick(); tick();
        chk("R8 irq high in reset", irq_n, 1);
        rst = 0; tick();
        chk("R8 irq high after reset", irq_n, 1);
        chk("R1 rd_byte reset", rd_byte, 0);

        // R1 reset contents, then R4 wrap on the 17th read
        do_start();
        for (int i = 0; i < 16; i++) begin get(v); chk("R1 reset value", v, rv(i)); end
        get(v); chk("R4 read wrap", v, 8'h08);

        // R5 all fields disabled: any trigger write matches
        bd(3, 8'h01); bd(4, 8'h01); bd(5, 8'h01); bd(6, 8'h05);
        chk("R8 flag without enable", irq_n, 1);
        read_at(1, v); chk("R5 vacuous match", v, 8'h08);

        // R2 burst write of the alarm fields, R3 consecutive reads
        do_start(); put(9); put(8'h02); put(8'h01); put(8'h01); put(8'h05);
        do_start(); put(9); do_start();
        get(v); chk("R2 burst alarm min", v, 8'h02);
        get(v); chk("R3 increment read", v, 8'h01);

        // R7 clear flag, R10 read after start without pointer
        write_reg(1, 8'h02);
        chk("R7 flag cleared", irq_n, 1);
        do_start(); get(v); chk("R10 read at old pointer", v, 8'h80);

        // R9 backdoor drives the match, R5 full match
        bd(3, 8'h02);
        chk("R9 backdoor match", irq_n, 0);
        bd(3, 8'h03);
        chk("R7 sticky on mismatch", irq_n, 0);
        bd(3, 8'h02);
        write_reg(1, 8'h02);
        chk("R7 cleared by write", irq_n, 1);

        // R6 non-trigger writes while fields already match
        write_reg(14, 8'h00); write_reg(2, 8'h45); write_reg(13, 8'h00);
        read_at(1, v); chk("R6 no trigger", v, 8'h02);
        chk("R6 irq stays high", irq_n, 1);
        write_reg(6, 8'h05);
        chk("R6 trigger on weekday write", irq_n, 0);

        // R5 disabled field ignored
        write_reg(1, 8'h02);
        bd(4, 8'h07);
        chk("R5 hour mismatch", irq_n, 1);
        write_reg(10, 8'h81);
        chk("R5 disabled hour ignored", irq_n, 0);

        // R9 collision: host write wins, backdoor dropped
        do_start(); put(1);
        wr_valid = 1; wr_byte = 8'h02; bd_we = 1; bd_addr = 4'd3; bd_data = 8'h09;
        tick(); wr_valid = 0; bd_we = 0;
        chk("R9 host write applied", irq_n, 1);
        read_at(3, v); chk("R9 backdoor dropped", v, 8'h02);

        // R4 write wrap from 0x0F to 0x00
        do_start(); put(15); put(8'h00); put(8'h18);
        read_at(0, v); chk("R4 write wrap", v, 8'h18);
        read_at(15, v); chk("R2 write at pointer", v, 8'h00);

        // R1 reset in mid-run
        rst = 1; tick(); tick(); rst = 0; tick();
        chk("R8 irq after reset", irq_n, 1);
        read_at(1, v); chk("R1 status word reset", v, 8'h00);
        read_at(0, v); chk("R1 control reset", v, 8'h08);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule